// File: doc/BRIEF.md
# S/PDIF Subframe Error Filter

This block sits between an S/PDIF subframe decoder and the path that writes captured audio to memory. It takes each decoded 32-bit subframe word and applies the error policy to it. The block computes the parity of the subframe itself. A subframe whose validity bit reports unusable audio keeps its payload. A subframe that fails parity has its payload replaced with zeros. Each of the two conditions sets its own sticky status flag. Software clears a flag by writing a one to it.

A raw-mode select bypasses the policy. In raw mode the whole decoded word goes to memory whatever its parity or validity, and neither status flag changes. Every accepted subframe gives exactly one registered output word, one clock cycle later.

Subframe word layout:
- bits 3:0 hold the preamble code.
- bits 27:4 hold the audio payload, with the least significant bit at bit 4.
- bit 28 is the validity bit, where 1 means the sample is flagged as unusable.
- bits 29 and 30 are the user bit and the channel-status bit.
- bit 31 is the parity bit.

Top module: `spdif_err_filter`

## Requirements
- R1: While `rst_n` is low, `out_stb`, `out_word`, `verr_flag` and `perr_flag` are all zero.
- R2: `out_stb` is high for exactly one cycle, on the cycle after each cycle in which `sf_stb` is high, and is low at all other times.
- R3: In normal mode (`raw_mode`=0), a subframe with correct parity and validity bit 28 = 0 gives `out_word` = {8'b0, sf_word[27:4]}.
- R4: In normal mode, a subframe with correct parity and validity bit 28 = 1 still gives `out_word` = {8'b0, sf_word[27:4]}, and `verr_flag` is set on the following cycle.
- R5: Parity is correct when the number of ones in `sf_word[31:4]` is even. In normal mode, a subframe with odd parity gives `out_word` = 0, and `perr_flag` is set on the following cycle.
- R6: In normal mode, a subframe with both odd parity and validity bit 28 = 1 gives `out_word` = 0 and sets both flags.
- R7: In raw mode (`raw_mode`=1), `out_word` equals the full 32-bit `sf_word`, whatever its parity and validity.
- R8: A raw-mode subframe does not set either status flag.
- R9: The flags are sticky. Writing a one to `stat_clr` bit 0 clears `verr_flag` on the next cycle, and writing a one to bit 1 clears `perr_flag`. Without a clear, a flag that is set stays set.
- R10: When a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R11: `out_word` keeps its last value in cycles with no input strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sf_stb | input | 1 | Decoded subframe present on `sf_word` |
| sf_word | input | 32 | Decoded subframe word |
| raw_mode | input | 1 | 1 = forward the whole word with no error policy |
| stat_clr | input | 2 | Write-one-to-clear: bit 0 clears the validity flag, bit 1 clears the parity flag |
| out_stb | output | 1 | Output word valid |
| out_word | output | 32 | Filtered payload, or the raw subframe word in raw mode |
| verr_flag | output | 1 | Sticky validity-error flag |
| perr_flag | output | 1 | Sticky parity-error flag |

## Verification
Each result is due one rising edge after the stimulus: `out_stb`, `out_word` and both flags all come from registers loaded at the edge that samples `sf_stb`, `raw_mode` and `stat_clr`. The bench changes inputs on the falling edge and works out the expected word and flags from its own model of the policy. It compares them at the next falling edge, so every comparison lands exactly one rising edge after the inputs it depends on. Directed cases cover:
- clean, validity-error, parity-error and double-error subframes;
- raw words with bad parity and a set validity bit;
- set and clear of a flag in the same cycle;
- idle gaps.

Randomized traffic then mixes these conditions cycle by cycle.

// File: rtl/spdif_err_filter.sv
module spdif_err_filter #(
  parameter int PAY_W   = 24,
  parameter int PAY_LSB = 4,
  localparam int V_POS  = PAY_LSB + PAY_W,
  localparam int SF_W   = V_POS + 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sf_stb,
  input  logic [SF_W-1:0] sf_word,
  input  logic            raw_mode,
  input  logic [1:0]      stat_clr,
  output logic            out_stb,
  output logic [SF_W-1:0] out_word,
  output logic            verr_flag,
  output logic            perr_flag
);

  localparam int PAD_W = SF_W - PAY_W;

  logic            par_bad;
  logic            v_bit;
  logic            verr_set;
  logic            perr_set;
  logic [SF_W-1:0] filt_word;
  logic [SF_W-1:0] nxt_word;

  assign par_bad   = ^sf_word[SF_W-1:PAY_LSB];
  assign v_bit     = sf_word[V_POS];
  assign filt_word = par_bad ? '0 : {{PAD_W{1'b0}}, sf_word[PAY_LSB +: PAY_W]};
  assign nxt_word  = raw_mode ? sf_word : filt_word;
  assign verr_set  = sf_stb & ~raw_mode & v_bit;
  assign perr_set  = sf_stb & ~raw_mode & par_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_stb   <= 1'b0;
      out_word  <= '0;
      verr_flag <= 1'b0;
      perr_flag <= 1'b0;
    end else begin
      out_stb   <= sf_stb;
      if (sf_stb) out_word <= nxt_word;
      verr_flag <= verr_set | (verr_flag & ~stat_clr[0]);
      perr_flag <= perr_set | (perr_flag & ~stat_clr[1]);
    end
  end

  // R2
  stb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_stb |=> out_stb);
  // R2
  stb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_stb |=> !out_stb);
  // R5
  par_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_stb && !raw_mode && (^sf_word[SF_W-1:PAY_LSB])) |=> (out_word == '0) && perr_flag);
  // R4
  val_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_stb && !raw_mode && sf_word[V_POS] && !(^sf_word[SF_W-1:PAY_LSB]))
      |=> (out_word[PAY_W-1:0] == $past(sf_word[PAY_LSB +: PAY_W])) && verr_flag);
  // R7
  raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_stb && raw_mode) |=> out_word == $past(sf_word));
  // R8
  raw_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_mode && !verr_flag && !perr_flag) |=> !verr_flag && !perr_flag);
  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_flag && !stat_clr[1]) |=> perr_flag);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_stb |=> $stable(out_word));

endmodule

// File: tb/spdif_err_filter_test.sv
module spdif_err_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sf_stb = 1'b0;
  logic [31:0] sf_word = '0;
  logic        raw_mode = 1'b0;
  logic [1:0]  stat_clr = '0;
  logic        out_stb;
  logic [31:0] out_word;
  logic        verr_flag, perr_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_word = '0;
  logic        m_verr = 1'b0, m_perr = 1'b0;

  always #5 clk = ~clk;

  spdif_err_filter uut (
    .clk(clk), .rst_n(rst_n), .sf_stb(sf_stb), .sf_word(sf_word),
    .raw_mode(raw_mode), .stat_clr(stat_clr), .out_stb(out_stb),
    .out_word(out_word), .verr_flag(verr_flag), .perr_flag(perr_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [23:0] pay, input logic v, input logic bad);
    logic [31:0] w;
    w = {1'b0, 2'($urandom), v, pay, 4'($urandom)};
    w[31] = (^w[30:4]) ^ bad;
    return w;
  endfunction

  task automatic step(input logic stb, input logic raw, input logic [31:0] w, input logic [1:0] clr);
    logic pb, vb, vs, ps;
    string wtag, vtag, ptag;
    sf_stb = stb; raw_mode = raw; sf_word = w; stat_clr = clr;
    pb = ^w[31:4];
    vb = w[28];
    vs = stb & ~raw & vb;
    ps = stb & ~raw & pb;
    if (!stb)       wtag = "R11";
    else if (raw)   wtag = "R7";
    else if (pb)    wtag = vb ? "R6" : "R5";
    else            wtag = vb ? "R4" : "R3";
    vtag = (stb && raw) ? "R8" : (vs && clr[0]) ? "R10" : vs ? "R4" : "R9";
    ptag = (stb && raw) ? "R8" : (ps && clr[1]) ? "R10" : ps ? "R5" : "R9";
    if (stb) m_word = raw ? w : (pb ? 32'h0 : {8'h0, w[27:4]});
    m_verr = vs | (m_verr & ~clr[0]);
    m_perr = ps | (m_perr & ~clr[1]);
    @(negedge clk);
    chk("R2 out_stb", {31'b0, out_stb}, {31'b0, stb});
    chk({wtag, " out_word"}, out_word, m_word);
    chk({vtag, " verr_flag"}, {31'b0, verr_flag}, {31'b0, m_verr});
    chk({ptag, " perr_flag"}, {31'b0, perr_flag}, {31'b0, m_perr});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    sf_stb = 1'b1; sf_word = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R1 out_stb", {31'b0, out_stb}, 32'h0);
    chk("R1 out_word", out_word, 32'h0);
    chk("R1 flags", {30'b0, verr_flag, perr_flag}, 32'h0);
    sf_stb = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    step(1, 0, mk(24'hA5A5A5, 0, 0), 2'b00);   // R3 clean
    step(0, 0, 32'h1234_5678, 2'b00);          // R11 hold
    step(1, 0, mk(24'h123456, 1, 0), 2'b00);   // R4 validity error
    step(0, 0, 32'h0, 2'b00);                  // R9 sticky
    step(1, 0, mk(24'hFEDCBA, 0, 1), 2'b00);   // R5 parity error
    step(0, 0, 32'h0, 2'b11);                  // R9 clear both
    step(1, 0, mk(24'h0F0F0F, 1, 1), 2'b00);   // R6 both errors
    step(0, 0, 32'h0, 2'b11);                  // R9 clear
    step(1, 1, mk(24'h777777, 1, 1), 2'b00);   // R7 / R8 raw, no flag update
    step(1, 1, 32'hFFFF_FFFF, 2'b00);          // R7 raw all ones
    step(1, 0, mk(24'h111111, 1, 1), 2'b11);   // R10 set beats clear
    step(0, 0, 32'h0, 2'b01);                  // R9 clear only validity
    step(0, 0, 32'h0, 2'b10);                  // R9 clear parity
    step(1, 0, mk(24'hFFFFFF, 0, 0), 2'b00);   // R3 full-scale payload

    for (int i = 0; i < 3000; i++) begin
      logic stb, raw, v, bad;
      logic [1:0] clr;
      stb = ($urandom % 4) != 0;
      raw = ($urandom % 5) == 0;
      v   = ($urandom % 4) == 0;
      bad = ($urandom % 4) == 0;
      clr = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
      step(stb, raw, mk(24'($urandom), v, bad), clr);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule